// File: doc/BRIEF.md
# Synchronous Serial Character Receiver

This block takes characters off a single serial data line whose bit timing comes from an external bit clock. The bit clock reaches the block as a one-cycle sample enable pulse, aligned to the system clock, at each of its rising edges. On each enabled sample the receiver looks at the line. While the line is idle and high, the receiver waits. A low sample marks a start bit. The samples after it are then taken in turn as 5 to 8 data bits, least significant bit first, then an optional parity bit, then a single stop bit. The receiver then goes back to waiting for the next start bit.

Each finished character is copied into a holding register and raises a ready flag. The block keeps three sticky error flags. Overrun is raised when a character arrives while the previous one is still unread. Parity error is raised when the received parity bit does not match the bit the selected mode expects. Framing error is raised when the stop bit is low and at least one data bit is high, so an all-zero break-like character does not raise it. The host clears the ready flag with a read strobe and clears the three error flags with a separate clear strobe.

Top module: `sync_char_rx`

## Requirements
- R1: The line is looked at only in cycles where `sample_en` is 1; in other cycles a change on `rxd` has no effect on reception.
- R2: While idle, a high sample keeps the receiver idle. A low sample is taken as a start bit.
- R3: `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data is received least significant bit first, and the unused upper bits of `rx_data` read as 0.
- R4: At the clock edge where the stop bit is sampled, the character is loaded into `rx_data` and `rx_ready` becomes 1, both visible right after that edge.
- R5: A one-cycle `rd_strobe` clears `rx_ready`.
- R6: `overrun` is set when a character completes while `rx_ready` is still 1 and no read happens in that cycle. The new character replaces the old one.
- R7: `par_mode` selects the parity bit: 0 = none (the stop bit follows the last data bit), 1 = even (bit equals the XOR of the data bits), 2 = odd (its inverse), 3 = always 0, 4 = always 1. Codes 5 to 7 behave as none.
- R8: `parity_err` is set when a parity mode is active and the received parity bit differs from the expected bit.
- R9: `frame_err` is set only when the stop bit is sampled low and at least one received data bit is 1.
- R10: The error flags are sticky. Later clean characters do not clear them. `clr_err` clears `overrun`, `parity_err` and `frame_err` and leaves `rx_ready` as it is.
- R11: After reset, `rx_data` is 0 and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | One-cycle pulse at each rising edge of the bit clock |
| rxd | input | 1 | Serial data line, idle high |
| len_sel | input | SEL_W (2) | Data length select, 5 + value bits |
| par_mode | input | 3 | Parity mode code |
| rd_strobe | input | 1 | Host read of the holding register |
| clr_err | input | 1 | Host clear of the error flags |
| rx_data | output | DATA_W (8) | Holding register |
| rx_ready | output | 1 | Character waiting |
| overrun | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity error flag |
| frame_err | output | 1 | Sticky framing error flag |

## Verification
The bench builds the receiver with its default parameters: 8-bit maximum width and a 5-bit minimum. At these sizes every data value of every length can be sent in every parity mode with no trimming, about 2400 characters in all. Deliberately wrong parity bits are swept over a spread of 8-bit values in each parity mode. A low stop bit is sent under all 256 8-bit values, so that framing is checked against the zero-data exception. Directed sequences cover overrun, stickiness across clean characters, gaps in `sample_en` with the line low, and unused parity codes.

// File: rtl/sync_rx_pkg.sv
// Package: types and helpers shared by the synchronous receiver.
// Assumes parity codes 0..4 are meaningful and any other code means "none".
package sync_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2,
        ST_STOP = 2'd3
    } rx_state_e;

    localparam logic [2:0] PM_NONE = 3'd0;
    localparam logic [2:0] PM_EVEN = 3'd1;
    localparam logic [2:0] PM_ODD  = 3'd2;
    localparam logic [2:0] PM_ZERO = 3'd3;
    localparam logic [2:0] PM_ONE  = 3'd4;

    // True when the mode inserts a parity bit between data and stop.
    function automatic logic parity_active(input logic [2:0] mode);
        return (mode >= PM_EVEN) && (mode <= PM_ONE);
    endfunction

endpackage

// File: rtl/sync_rx_deframe.sv
// Module: deframer. Walks the line through start, data, parity and stop
// on each sample enable, and shifts the data in least significant bit first.
// Assumes sample_en is already aligned to clk and lasts one cycle per bit.
// Emits a one-cycle 'done' in the cycle the stop bit is sampled, together
// with the data word, the captured parity bit and the live stop bit.
module sync_rx_deframe
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MIN_W  = 5,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rxd,
    input  logic [SEL_W-1:0]  len_sel,
    input  logic              par_on,
    output logic              done,
    output logic [DATA_W-1:0] data_o,
    output logic              par_bit_o,
    output logic              stop_bit_o
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   last_idx;
    logic [DATA_W-1:0]  shreg;
    logic               par_q;

    // Index of the final data bit, clamped to the register width.
    always_comb begin
        int tmp;
        tmp = MIN_W - 1 + int'(len_sel);
        if (tmp > DATA_W - 1) tmp = DATA_W - 1;
        last_idx = CNT_W'(tmp);
    end

    // Frame state machine with data shift and parity capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            par_q <= 1'b0;
        end else if (sample_en) begin
            case (state)
                ST_IDLE: begin
                    if (!rxd) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                        shreg <= '0;
                    end
                end
                ST_DATA: begin
                    shreg[cnt] <= rxd;
                    if (cnt == last_idx) begin
                        state <= par_on ? ST_PAR : ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    par_q <= rxd;
                    state <= ST_STOP;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign done       = sample_en && (state == ST_STOP);
    assign data_o     = shreg;
    assign par_bit_o  = par_q;
    assign stop_bit_o = rxd;

    // Without a sample enable, the frame position must not move.
    assert_no_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(state) && $stable(cnt)));

    // An idle receiver leaves idle only on a low sample.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !(sample_en && !rxd)) |=> (state == ST_IDLE));

endmodule

// File: rtl/sync_rx_check.sv
// Module: character checker. Purely combinational. Works out the expected
// parity bit for the mode in force and the framing verdict for a finished
// character. Assumes its inputs are valid only while 'done' is high upstream.
module sync_rx_check
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MIN_W  = 5,
    parameter int SEL_W  = 2
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SEL_W-1:0]  len_sel,
    input  logic [2:0]        par_mode,
    input  logic              par_bit_i,
    input  logic              stop_bit_i,
    output logic              parity_bad,
    output logic              frame_bad
);

    logic [DATA_W-1:0] mask;
    logic              ones_odd;
    logic              exp_bit;

    // Mask of the bits that belong to the current data length.
    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_mask
            assign mask[g] = (g < MIN_W) ? 1'b1 : (int'(len_sel) >= (g - MIN_W + 1));
        end
    endgenerate

    // Expected parity bit for the mode in force.
    always_comb begin
        ones_odd = ^(data_i & mask);
        case (par_mode)
            PM_EVEN: exp_bit = ones_odd;
            PM_ODD:  exp_bit = ~ones_odd;
            PM_ZERO: exp_bit = 1'b0;
            PM_ONE:  exp_bit = 1'b1;
            default: exp_bit = 1'b0;
        endcase
    end

    // Error verdicts: parity mismatch, and low stop bit with non-zero data.
    always_comb begin
        parity_bad = parity_active(par_mode) && (par_bit_i != exp_bit);
        frame_bad  = !stop_bit_i && (|data_i);
    end

endmodule

// File: rtl/sync_rx_status.sv
// Module: holding register and status flags. Loads the character on 'done',
// keeps ready and three sticky error flags, and serves the host strobes.
// A read in the same cycle as a new character takes the old one, so no
// overrun is raised. A new error wins over a clear in the same cycle.
module sync_rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data_i,
    input  logic              parity_bad,
    input  logic              frame_bad,
    input  logic              rd_strobe,
    input  logic              clr_err,
    output logic [DATA_W-1:0] hold_o,
    output logic              ready_o,
    output logic              ovr_o,
    output logic              pe_o,
    output logic              fe_o
);

    // Holding register: loads only when a character completes.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_o <= '0;
        else if (done) hold_o <= data_i;
    end

    // Ready flag: set by a finished character, cleared by a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)         ready_o <= 1'b0;
        else if (done)      ready_o <= 1'b1;
        else if (rd_strobe) ready_o <= 1'b0;
    end

    // Sticky error flags: set on events, cleared only by the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_o <= 1'b0;
            pe_o  <= 1'b0;
            fe_o  <= 1'b0;
        end else begin
            if (done && ready_o && !rd_strobe) ovr_o <= 1'b1;
            else if (clr_err)                  ovr_o <= 1'b0;
            if (done && parity_bad)            pe_o  <= 1'b1;
            else if (clr_err)                  pe_o  <= 1'b0;
            if (done && frame_bad)             fe_o  <= 1'b1;
            else if (clr_err)                  fe_o  <= 1'b0;
        end
    end

    assert_ready_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready_o);

    assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !done) |=> !ready_o);

    assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $past(done && ready_o && !rd_strobe));

    assert_frame_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_o) |-> $past(done && frame_bad));

    assert_sticky_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pe_o || fe_o || ovr_o) && !clr_err) |=> (pe_o || fe_o || ovr_o));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(hold_o));

endmodule

// File: rtl/sync_char_rx.sv
// Module: top of the synchronous character receiver. Connects the
// deframer, the checker and the status block. Assumes all inputs are
// synchronous to clk and that the bit clock arrives as sample_en pulses.
module sync_char_rx
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MIN_W  = 5,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rxd,
    input  logic [SEL_W-1:0]  len_sel,
    input  logic [2:0]        par_mode,
    input  logic              rd_strobe,
    input  logic              clr_err,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              overrun,
    output logic              parity_err,
    output logic              frame_err
);

    logic              done;
    logic [DATA_W-1:0] word;
    logic              par_bit;
    logic              stop_bit;
    logic              parity_bad;
    logic              frame_bad;

    sync_rx_deframe #(.DATA_W(DATA_W), .MIN_W(MIN_W), .SEL_W(SEL_W)) u_deframe (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .rxd        (rxd),
        .len_sel    (len_sel),
        .par_on     (parity_active(par_mode)),
        .done       (done),
        .data_o     (word),
        .par_bit_o  (par_bit),
        .stop_bit_o (stop_bit)
    );

    sync_rx_check #(.DATA_W(DATA_W), .MIN_W(MIN_W), .SEL_W(SEL_W)) u_check (
        .data_i     (word),
        .len_sel    (len_sel),
        .par_mode   (par_mode),
        .par_bit_i  (par_bit),
        .stop_bit_i (stop_bit),
        .parity_bad (parity_bad),
        .frame_bad  (frame_bad)
    );

    sync_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .data_i     (word),
        .parity_bad (parity_bad),
        .frame_bad  (frame_bad),
        .rd_strobe  (rd_strobe),
        .clr_err    (clr_err),
        .hold_o     (rx_data),
        .ready_o    (rx_ready),
        .ovr_o      (overrun),
        .pe_o       (parity_err),
        .fe_o       (frame_err)
    );

endmodule

// File: tb/sync_char_rx_bench.sv
module sync_char_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic [2:0] par_mode = 3'd0;
    logic       rd_strobe = 1'b0;
    logic       clr_err = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, overrun, parity_err, frame_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sync_char_rx u_sync_char_rx (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
        .len_sel(len_sel), .par_mode(par_mode), .rd_strobe(rd_strobe),
        .clr_err(clr_err), .rx_data(rx_data), .rx_ready(rx_ready),
        .overrun(overrun), .parity_err(parity_err), .frame_err(frame_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk); rxd = b; sample_en = 1'b1;
        @(negedge clk); sample_en = 1'b0;
    endtask

    function automatic logic exp_par(input int len, input int mode, input int d);
        logic x;
        x = ^(d[7:0] & 8'((1 << len) - 1));
        case (mode)
            1: return x;
            2: return ~x;
            4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_char(input int len, input int mode, input int d,
                             input logic flip, input logic stop);
        bit_out(1'b0);
        for (int i = 0; i < len; i++) bit_out(d[i]);
        if (mode >= 1 && mode <= 4) bit_out(exp_par(len, mode, d) ^ flip);
        bit_out(stop);
        @(negedge clk); rxd = 1'b1;
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 data", rx_data, 0);
        chk("R11 ready", rx_ready, 0);
        chk("R11 flags", {overrun, parity_err, frame_err}, 0);

        // R3 R4 R7 R5: every length, every mode, every value
        for (int ls = 0; ls < 4; ls++) begin
            for (int m = 0; m < 5; m++) begin
                for (int d = 0; d < (1 << (ls + 5)); d++) begin
                    len_sel = 2'(ls); par_mode = 3'(m);
                    send_char(ls + 5, m, d, 1'b0, 1'b1);
                    chk("R3 data", rx_data, d);
                    chk("R4 ready", rx_ready, 1);
                    chk("R7 clean flags", {overrun, parity_err, frame_err}, 0);
                    do_read();
                    chk("R5 ready cleared", rx_ready, 0);
                end
            end
        end

        // R8: wrong parity bit in each mode, then R10 clear
        len_sel = 2'd3;
        for (int m = 1; m < 5; m++) begin
            for (int d = 0; d < 256; d += 17) begin
                par_mode = 3'(m);
                send_char(8, m, d, 1'b1, 1'b1);
                chk("R8 parity err", parity_err, 1);
                chk("R8 data kept", rx_data, d);
                do_read();
                do_clear();
                chk("R10 parity cleared", parity_err, 0);
            end
        end

        // R9: low stop bit, framing only with a one in the data
        par_mode = 3'd0;
        for (int d = 0; d < 256; d++) begin
            send_char(8, 0, d, 1'b0, 1'b0);
            chk("R9 frame err", frame_err, (d != 0) ? 1 : 0);
            do_read();
            do_clear();
        end

        // R7: code 5 behaves as no parity
        par_mode = 3'd5;
        send_char(8, 0, 8'hA5, 1'b0, 1'b1);
        chk("R7 code5 data", rx_data, 8'hA5);
        chk("R7 code5 flags", {parity_err, frame_err}, 0);
        do_read();

        // R6: two characters without a read
        par_mode = 3'd0;
        send_char(8, 0, 8'h11, 1'b0, 1'b1);
        chk("R6 no overrun yet", overrun, 0);
        send_char(8, 0, 8'h22, 1'b0, 1'b1);
        chk("R6 overrun", overrun, 1);
        chk("R6 newest data", rx_data, 8'h22);
        do_read();
        // R10: sticky across a clean character, clear leaves ready alone
        send_char(8, 0, 8'h33, 1'b0, 1'b1);
        chk("R10 overrun sticky", overrun, 1);
        do_clear();
        chk("R10 overrun cleared", overrun, 0);
        chk("R10 ready untouched", rx_ready, 1);
        do_read();

        // R2: idle high line with enables produces nothing
        for (int i = 0; i < 20; i++) bit_out(1'b1);
        chk("R2 idle no char", rx_ready, 0);

        // R1: line low without sample enable does not start a frame
        @(negedge clk); rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        @(negedge clk);
        chk("R1 no start", rx_ready, 0);
        send_char(8, 0, 8'h5C, 1'b0, 1'b1);
        chk("R1 aligned data", rx_data, 8'h5C);
        chk("R1 no frame err", frame_err, 0);
        do_read();

        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (190000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule